// File: doc/BRIEF.md
# Management-Mode State Save and Resume Sequencer

This block moves a processor core in and out of its system management mode. When a management interrupt is requested, it writes a fixed set of 32-bit architectural state words to a save area in memory, one word at a time, through a request/acknowledge memory port. It then gives the core an entry image of that state, with the instruction pointer, flags, debug and control registers forced to the values that management code expects. On a resume command it reads the same words back from the save area. It gives them to the core unchanged, and it can move the save area base if the saved revision word asks for it.

The core exposes its state on a parallel bus, one 32-bit word per slot, and takes new state from a second parallel bus on a one-cycle load strobe. The block also tracks whether non-maskable interrupts are blocked, so that a management entry made from inside an NMI handler does not unblock NMIs early on resume.

Top module: `smm_seq`

## Requirements
- R1: After reset, busy, mem_req, st_load, rsm_err, smm_active, nmi_blocked and inside_nmi are 0, and smbase equals the parameter DEF_BASE (default 0x0003_0000).
- R2: On entry, state word k of st_in (bits 32k+31..32k) is written to address smbase + 0x8000 + offset(k). The offsets are, for k = 0..18: 0x7ffc, 0x7ff8, 0x7ff4, 0x7ff0, then 0x7fec down to 0x7fd0 in steps of 4 for k = 4..11, then 0x7fcc, 0x7fc8, 0x7f74, 0x7f70, 0x7f58, 0x7f54, 0x7f14. The words are control register 0, control register 3, flags, instruction pointer, eight general registers, debug registers 6 and 7, descriptor table 1 base and limit, descriptor table 2 base and limit, and control register 4.
- R3: On entry, the parameter REV_ID (default 0x0002_0064) is written to offset 0x7efc and the current smbase to offset 0x7ef8, after the 19 state words.
- R4: The entry image on st_out equals st_in, with these changes: word 0 has bits 0, 2, 3 and 31 cleared; word 2 (flags) is 0; word 3 (instruction pointer) is 0x8000; word 13 (debug register 7) is 0x400; word 18 (control register 4) is 0.
- R5: Each transfer holds mem_req, mem_we, mem_addr and mem_wdata steady until mem_ack is sampled high, then moves to the next word. Busy rises in the cycle after smi_req or rsm_req is accepted and stays high until the edge that samples the last acknowledge. At that edge, st_load pulses for exactly one cycle.
- R6: On entry, if nmi_blocked was already 1, inside_nmi is set to 1. Otherwise nmi_blocked is set to 1. Outside a sequence, nmi_take sets nmi_blocked and nmi_ret clears it.
- R7: On resume, the 21 words are read from the same addresses as in R2 and R3 (mem_we 0), st_out carries the 19 words read, unchanged, when st_load pulses, and smm_active becomes 0.
- R8: On resume, nmi_blocked is cleared only if inside_nmi was 0. inside_nmi is always cleared.
- R9: On resume, if bit 17 of the word read from offset 0x7efc is 1, smbase becomes the word read from offset 0x7ef8 with bits 14..0 cleared. Otherwise smbase is unchanged.
- R10: rsm_req while smm_active is 0 starts no transfer and pulses rsm_err for one cycle.
- R11: smi_req while smm_active is 1 is ignored: busy stays 0 and no transfer starts.
- R12: smbase always has bits 14..0 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smi_req | input | 1 | Management interrupt request |
| rsm_req | input | 1 | Resume command |
| nmi_take | input | 1 | Core delivered an NMI (blocks further NMIs) |
| nmi_ret | input | 1 | Core left its NMI handler (unblocks NMIs) |
| st_in | input | 608 | Core state words, word k at bits 32k+31..32k |
| st_out | output | 608 | State for the core to load, same packing |
| st_load | output | 1 | One-cycle strobe: the core loads st_out |
| smm_active | output | 1 | Core is in management mode |
| nmi_blocked | output | 1 | NMIs are blocked |
| inside_nmi | output | 1 | Management mode was entered with NMIs already blocked |
| busy | output | 1 | A save or restore sequence is running |
| rsm_err | output | 1 | One-cycle pulse: resume requested outside management mode |
| smbase | output | 32 | Current management base |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer complete |

## Verification
Busy is due at the first falling edge after the edge that samples smi_req or rsm_req, and rsm_err is due at that same falling edge. The results of a sequence (st_load, st_out, the NMI flags, smm_active and smbase) all become valid together, at the falling edge after the edge that samples the last acknowledge. The bench never counts cycles towards that point: it waits for the st_load pulse and samples everything at that falling edge. The memory model adds 0 to 3 wait cycles per word, and the bench checks the save area contents against addresses it computes itself.

// File: rtl/smm_seq_pkg.sv
package smm_seq_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned N_STATE  = 19;              // architectural words
   localparam int unsigned N_SLOT   = N_STATE + 2;     // plus revision and base
   localparam int unsigned IX_W     = $clog2(N_SLOT);

   localparam int unsigned IX_CR0   = 0;
   localparam int unsigned IX_FLAGS = 2;
   localparam int unsigned IX_IP    = 3;
   localparam int unsigned IX_DR7   = 13;
   localparam int unsigned IX_CR4   = 18;
   localparam int unsigned IX_REV   = 19;
   localparam int unsigned IX_BASE  = 20;

   localparam logic [31:0] AREA_OFS    = 32'h0000_8000;
   localparam logic [31:0] ENTRY_IP    = 32'h0000_8000;
   localparam logic [31:0] ENTRY_DR7   = 32'h0000_0400;
   localparam logic [31:0] CR0_KEEP    = 32'h7FFF_FFF2;   // clears bits 31,3,2,0
   localparam logic [31:0] BASE_ALIGN  = 32'hFFFF_8000;
   localparam int unsigned RELOC_BIT   = 17;

   typedef enum logic [1:0] {PH_IDLE, PH_SAVE, PH_LOAD} phase_e;

   // byte offset of slot k inside the save area
   function automatic logic [15:0] slot_offset(input int unsigned k);
      logic [15:0] ofs;
      if (k < 14) ofs = 16'h7ffc - 16'(4 * k);
      else begin
         case (k)
            14:      ofs = 16'h7f74;
            15:      ofs = 16'h7f70;
            16:      ofs = 16'h7f58;
            17:      ofs = 16'h7f54;
            18:      ofs = 16'h7f14;
            19:      ofs = 16'h7efc;
            default: ofs = 16'h7ef8;
         endcase
      end
      return ofs;
   endfunction

endpackage

// File: rtl/smm_slot_addr.sv
module smm_slot_addr
   import smm_seq_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic [AW-1:0]   base,
   input  logic [IX_W-1:0] idx,
   output logic [AW-1:0]   addr
);

   if (AW < 20 || AW > 32) begin : g_bad_aw
      $error("smm_slot_addr: AW must lie in 20..32");
   end

   always_comb begin
      addr = base + AW'(AREA_OFS) + AW'(slot_offset(int'(idx)));
   end

endmodule

// File: rtl/smm_entry_image.sv
module smm_entry_image
   import smm_seq_pkg::*;
(
   input  logic [WORD_W-1:0] cur [N_STATE],
   output logic [WORD_W-1:0] img [N_STATE]
);

   for (genvar k = 0; k < N_STATE; k++) begin : g_word
      if (k == IX_CR0) begin : g_cr0
         assign img[k] = cur[k] & CR0_KEEP;
      end else if (k == IX_FLAGS || k == IX_CR4) begin : g_zero
         assign img[k] = '0;
      end else if (k == IX_IP) begin : g_ip
         assign img[k] = ENTRY_IP;
      end else if (k == IX_DR7) begin : g_dr7
         assign img[k] = ENTRY_DR7;
      end else begin : g_keep
         assign img[k] = cur[k];
      end
   end

endmodule

// File: rtl/smm_nmi_track.sv
module smm_nmi_track (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_take,
   input  logic nmi_ret,
   input  logic enter_done,
   input  logic resume_done,
   output logic nmi_blocked,
   output logic inside_nmi
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_blocked <= 1'b0;
         inside_nmi  <= 1'b0;
      end else if (enter_done) begin
         inside_nmi  <= nmi_blocked;
         nmi_blocked <= 1'b1;
      end else if (resume_done) begin
         if (!inside_nmi) nmi_blocked <= 1'b0;
         inside_nmi <= 1'b0;
      end else if (nmi_take) begin
         nmi_blocked <= 1'b1;
      end else if (nmi_ret) begin
         nmi_blocked <= 1'b0;
      end
   end

   a_r6_entry_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      enter_done |=> nmi_blocked);
   a_r6_inside_marks: assert property (@(posedge clk) disable iff (!rst_n)
      enter_done && nmi_blocked |=> inside_nmi);
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      resume_done && !inside_nmi |=> !nmi_blocked);
   a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
      resume_done && inside_nmi |=> nmi_blocked && !inside_nmi);

endmodule

// File: rtl/smm_seq.sv
module smm_seq
   import smm_seq_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter logic [31:0] DEF_BASE = 32'h0003_0000,
   parameter logic [31:0] REV_ID   = 32'h0002_0064
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        smi_req,
   input  logic                        rsm_req,
   input  logic                        nmi_take,
   input  logic                        nmi_ret,
   input  logic [N_STATE*WORD_W-1:0]   st_in,
   output logic [N_STATE*WORD_W-1:0]   st_out,
   output logic                        st_load,
   output logic                        smm_active,
   output logic                        nmi_blocked,
   output logic                        inside_nmi,
   output logic                        busy,
   output logic                        rsm_err,
   output logic [AW-1:0]               smbase,
   output logic                        mem_req,
   output logic                        mem_we,
   output logic [AW-1:0]               mem_addr,
   output logic [WORD_W-1:0]           mem_wdata,
   input  logic [WORD_W-1:0]           mem_rdata,
   input  logic                        mem_ack
);

   if (DEF_BASE[14:0] != 15'd0) begin : g_bad_base
      $error("smm_seq: DEF_BASE must be 32 KiB aligned");
   end
   if (AW < 20 || AW > 32) begin : g_bad_aw
      $error("smm_seq: AW must lie in 20..32");
   end

   phase_e             phase;
   logic [IX_W-1:0]    idx;
   logic [WORD_W-1:0]  cur_w  [N_STATE];
   logic [WORD_W-1:0]  img_w  [N_STATE];
   logic [WORD_W-1:0]  out_q  [N_STATE];
   logic               rev_reloc;
   logic               last_slot;
   logic               enter_done;
   logic               resume_done;

   for (genvar k = 0; k < N_STATE; k++) begin : g_pack
      assign cur_w[k] = st_in[k*WORD_W +: WORD_W];
      assign st_out[k*WORD_W +: WORD_W] = out_q[k];
   end

   smm_slot_addr #(.AW(AW)) u_addr (
      .base (smbase),
      .idx  (idx),
      .addr (mem_addr)
   );

   smm_entry_image u_image (
      .cur (cur_w),
      .img (img_w)
   );

   assign last_slot   = (idx == IX_W'(N_SLOT - 1));
   assign busy        = (phase != PH_IDLE);
   assign mem_req     = busy;
   assign mem_we      = (phase == PH_SAVE);
   assign enter_done  = (phase == PH_SAVE) && mem_ack && last_slot;
   assign resume_done = (phase == PH_LOAD) && mem_ack && last_slot;

   always_comb begin
      if (idx == IX_W'(IX_REV))       mem_wdata = REV_ID;
      else if (idx == IX_W'(IX_BASE)) mem_wdata = WORD_W'(smbase);
      else if (idx < IX_W'(N_STATE))  mem_wdata = cur_w[idx];
      else                            mem_wdata = '0;
   end

   smm_nmi_track u_nmi (
      .clk         (clk),
      .rst_n       (rst_n),
      .nmi_take    (nmi_take),
      .nmi_ret     (nmi_ret),
      .enter_done  (enter_done),
      .resume_done (resume_done),
      .nmi_blocked (nmi_blocked),
      .inside_nmi  (inside_nmi)
   );

   // sequencing, mode flag and base register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         idx        <= '0;
         smm_active <= 1'b0;
         smbase     <= AW'(DEF_BASE);
         st_load    <= 1'b0;
         rsm_err    <= 1'b0;
         rev_reloc  <= 1'b0;
      end else begin
         st_load <= 1'b0;
         rsm_err <= 1'b0;
         case (phase)
            PH_IDLE: begin
               idx <= '0;
               if (!smm_active && smi_req)     phase <= PH_SAVE;
               else if (smm_active && rsm_req) phase <= PH_LOAD;
               if (!smm_active && rsm_req)     rsm_err <= 1'b1;
            end
            PH_SAVE: begin
               if (mem_ack) begin
                  if (last_slot) begin
                     phase      <= PH_IDLE;
                     smm_active <= 1'b1;
                     st_load    <= 1'b1;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            PH_LOAD: begin
               if (mem_ack) begin
                  if (idx == IX_W'(IX_REV)) rev_reloc <= mem_rdata[RELOC_BIT];
                  if (last_slot) begin
                     phase      <= PH_IDLE;
                     smm_active <= 1'b0;
                     st_load    <= 1'b1;
                     if (rev_reloc) smbase <= AW'(mem_rdata & BASE_ALIGN);
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // state image presented to the core
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_STATE; k++) out_q[k] <= '0;
      end else if (enter_done) begin
         for (int k = 0; k < N_STATE; k++) out_q[k] <= img_w[k];
      end else if (phase == PH_LOAD && mem_ack && idx < IX_W'(N_STATE)) begin
         out_q[idx] <= mem_rdata;
      end
   end

   a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));
   a_r5_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      st_load |=> !st_load);
   a_r5_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
      st_load |-> !busy);
   a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rsm_err |-> !busy && !smm_active);
   a_r11_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      smm_active && !busy && smi_req && !rsm_req |=> !busy);
   a_r12_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      smbase[14:0] == 15'd0);
   a_r6_inside_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
      inside_nmi |-> smm_active);

endmodule

// File: tb/smm_seq_test.sv
module smm_seq_test;
   import smm_seq_pkg::*;

   localparam logic [31:0] DEF_BASE = 32'h0003_0000;
   localparam logic [31:0] REV_ID   = 32'h0002_0064;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smi_req = 1'b0, rsm_req = 1'b0, nmi_take = 1'b0, nmi_ret = 1'b0;
   logic [N_STATE*32-1:0] st_in = '0;
   logic [N_STATE*32-1:0] st_out;
   logic st_load, smm_active, nmi_blocked, inside_nmi, busy, rsm_err;
   logic [31:0] smbase, mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic mem_req, mem_we;
   logic mem_ack = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   smm_seq #(.AW(32), .DEF_BASE(DEF_BASE), .REV_ID(REV_ID)) uut (
      .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .rsm_req(rsm_req),
      .nmi_take(nmi_take), .nmi_ret(nmi_ret), .st_in(st_in), .st_out(st_out),
      .st_load(st_load), .smm_active(smm_active), .nmi_blocked(nmi_blocked),
      .inside_nmi(inside_nmi), .busy(busy), .rsm_err(rsm_err), .smbase(smbase),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   int n_checks = 0;
   int n_fail = 0;
   int n_wr = 0;
   int n_rd = 0;
   int lat = 0;
   int wcnt = 0;
   int cyc = 0;
   logic [31:0] mem [logic [31:0]];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ofs_of(input int k);
      int t [7] = '{'h7f74, 'h7f70, 'h7f58, 'h7f54, 'h7f14, 'h7efc, 'h7ef8};
      if (k < 14) return 32'('h7ffc - 4 * k);
      return 32'(t[k - 14]);
   endfunction

   function automatic logic [31:0] pat(input int k, input int s);
      return (32'h1357_0000 * 32'(s + 1)) ^ (32'(k) * 32'h0101_0107) ^ 32'hA5A5_0F0F;
   endfunction

   // memory responder: ack after lat wait cycles, one-cycle ack
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
         wcnt = 0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            if (mem_we) begin
               mem[mem_addr] = mem_wdata;
               n_wr++;
            end else begin
               mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
               n_rd++;
            end
            mem_ack <= 1'b1;
         end else begin
            wcnt++;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic pulse_smi();
      @(negedge clk) smi_req = 1'b1;
      @(negedge clk) smi_req = 1'b0;
   endtask

   task automatic pulse_rsm();
      @(negedge clk) rsm_req = 1'b1;
      @(negedge clk) rsm_req = 1'b0;
   endtask

   task automatic wait_load();
      while (st_load !== 1'b1) @(negedge clk);
   endtask

   logic [31:0] base_m;
   logic [31:0] stored_b;
   logic [31:0] exp_w;
   bit pre_nmi;
   bit reloc;

   initial begin
      base_m = DEF_BASE;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({busy, mem_req, st_load, rsm_err, smm_active, nmi_blocked, inside_nmi} == 7'b0,
            "R1 outputs idle", {25'b0, busy, mem_req, st_load, rsm_err, smm_active,
            nmi_blocked, inside_nmi}, 32'h0);
      check(smbase == DEF_BASE, "R1 smbase", smbase, DEF_BASE);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 resume outside management mode
      pulse_rsm();
      check(rsm_err == 1'b1, "R10 rsm_err pulse", 32'(rsm_err), 32'h1);
      check(busy == 1'b0, "R10 no busy", 32'(busy), 32'h0);
      @(negedge clk);
      check(rsm_err == 1'b0 && mem_req == 1'b0 && n_rd == 0 && n_wr == 0,
            "R10 no transfer, single pulse", 32'(n_rd + n_wr), 32'h0);

      for (int it = 0; it < 4; it++) begin
         lat = it;
         pre_nmi = (it % 2) == 1;
         for (int k = 0; k < N_STATE; k++) st_in[k*32 +: 32] = pat(k, it);
         if (pre_nmi) begin
            @(negedge clk) nmi_take = 1'b1;
            @(negedge clk) nmi_take = 1'b0;
         end
         n_wr = 0; n_rd = 0;
         pulse_smi();
         check(busy == 1'b1, "R5 busy after smi", 32'(busy), 32'h1);
         wait_load();
         check(busy == 1'b0 && smm_active == 1'b1, "R5 entry done",
               {30'b0, busy, smm_active}, 32'h1);
         check(n_wr == N_SLOT, "R5 one write per slot", n_wr, N_SLOT);
         // R2 save area contents
         for (int k = 0; k < N_STATE; k++) begin
            logic [31:0] a;
            a = base_m + 32'h8000 + ofs_of(k);
            check(mem.exists(a) && mem[a] == pat(k, it), "R2 saved word",
                  mem.exists(a) ? mem[a] : 32'hDEAD_DEAD, pat(k, it));
         end
         check(mem[base_m + 32'h8000 + 32'h7efc] == REV_ID, "R3 revision word",
               mem[base_m + 32'h8000 + 32'h7efc], REV_ID);
         check(mem[base_m + 32'h8000 + 32'h7ef8] == base_m, "R3 base word",
               mem[base_m + 32'h8000 + 32'h7ef8], base_m);
         // R4 entry image
         for (int k = 0; k < N_STATE; k++) begin
            case (k)
               0:       exp_w = pat(k, it) & ~32'h8000_000D;
               2, 18:   exp_w = 32'h0;
               3:       exp_w = 32'h0000_8000;
               13:      exp_w = 32'h0000_0400;
               default: exp_w = pat(k, it);
            endcase
            check(st_out[k*32 +: 32] == exp_w, "R4 entry image", st_out[k*32 +: 32], exp_w);
         end
         // R6 NMI on entry
         check(nmi_blocked == 1'b1, "R6 nmi blocked", 32'(nmi_blocked), 32'h1);
         check(inside_nmi == pre_nmi, "R6 inside flag", 32'(inside_nmi), 32'(pre_nmi));
         @(negedge clk);
         check(st_load == 1'b0, "R5 load one cycle", 32'(st_load), 32'h0);

         // R11 second request ignored
         pulse_smi();
         check(busy == 1'b0, "R11 smi ignored", 32'(busy), 32'h0);
         @(negedge clk);
         check(busy == 1'b0 && n_wr == N_SLOT, "R11 no transfer", n_wr, N_SLOT);

         // prepare resume image
         reloc = (it % 2) == 0;
         stored_b = (it == 0) ? 32'h0005_7ABC : 32'h0001_FFFF;
         for (int k = 0; k < N_STATE; k++) mem[base_m + 32'h8000 + ofs_of(k)] = pat(k, it + 8);
         mem[base_m + 32'h8000 + 32'h7efc] = reloc ? 32'h0002_0000 : 32'hFFFD_FFFF;
         mem[base_m + 32'h8000 + 32'h7ef8] = stored_b;
         n_rd = 0;
         pulse_rsm();
         check(busy == 1'b1, "R5 busy after rsm", 32'(busy), 32'h1);
         wait_load();
         check(smm_active == 1'b0, "R7 mode left", 32'(smm_active), 32'h0);
         check(n_rd == N_SLOT, "R7 one read per slot", n_rd, N_SLOT);
         for (int k = 0; k < N_STATE; k++)
            check(st_out[k*32 +: 32] == pat(k, it + 8), "R7 restored word",
                  st_out[k*32 +: 32], pat(k, it + 8));
         if (reloc) base_m = stored_b & 32'hFFFF_8000;
         check(smbase == base_m, "R9 base after resume", smbase, base_m);
         check(smbase[14:0] == 15'd0, "R12 base aligned", smbase, smbase & 32'hFFFF_8000);
         check(nmi_blocked == pre_nmi, "R8 nmi after resume", 32'(nmi_blocked), 32'(pre_nmi));
         check(inside_nmi == 1'b0, "R8 inside cleared", 32'(inside_nmi), 32'h0);
         if (pre_nmi) begin
            @(negedge clk) nmi_ret = 1'b1;
            @(negedge clk) nmi_ret = 1'b0;
            check(nmi_blocked == 1'b0, "R6 nmi_ret unblocks", 32'(nmi_blocked), 32'h0);
         end
         @(negedge clk);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule